// File: doc/BRIEF.md
# LVDS Receive Deserializer and Pixel Unpacker

This block sits behind the LVDS line receivers and bit-slot sampler of a flat-panel link. On every clock it takes one sampled bit from the clock lane and one from each data lane. It finds the 7-slot pixel word boundary by looking for the fixed clock-lane shape, confirms that the boundary repeats, and then turns each 7-slot word back into a pixel. The pixel has 8-bit red, green and blue components plus horizontal sync, vertical sync and data enable.

Three colour packings are supported, selected by `map_sel`. The first is a 6-bit-per-colour packing on three data lanes. The other two are 8-bit packings that use a fourth lane, which carries either the two lowest or the two highest bits of each colour. A mirror input handles transmitters that send each word's slots in reverse order. Lock is held through a single damaged word and is dropped after repeated damage, after which the boundary search starts again. A reserved control slot that arrives set in an 8-bit packing raises a sticky error flag.

Top module: `lvds_rx_unpack`

## Requirements
- R1: While `rst_n` is low and directly after reset, `locked`, `pix_valid` and `ctl3_err` are 0.
- R2: A word counts as good when its clock-lane slots 0..6 read 1,1,0,0,0,1,1. `locked` rises after the third consecutive good word at one phase. `pix_valid` pulses for one cycle for that third word and for every later good word while locked, one clock after the word's last slot is sampled, with the decoded fields held on the pixel outputs.
- R3: Alignment is found from any slot offset of the incoming stream. Slots received before the first good word produce no pixel.
- R4: While locked, one bad word (clock lane not matching) produces no pixel and keeps `locked` at 1. A second consecutive bad word clears `locked`.
- R5: After lock is lost the search restarts, and `locked` returns after three further consecutive good words.
- R6: `map_sel`=0 (and the reserved value 3) selects the 6-bit packing. Lane 0 slot 0 carries green bit 0 and slots 1..6 carry red bits 5..0. Lane 1 slots 0,1 carry blue bits 1,0 and slots 2..6 carry green bits 5..1. Lane 2 slots 3..6 carry blue bits 5..2. Each 6-bit colour c is output as {c[5:0], c[5:4]}, and lane 3 is ignored.
- R7: `map_sel`=1 selects an 8-bit packing in which lanes 0..2 carry colour bits 7..2 at the R6 positions. Lane 3 slots 1,2 carry blue bits 1,0, slots 3,4 carry green bits 1,0 and slots 5,6 carry red bits 1,0.
- R8: `map_sel`=2 selects an 8-bit packing in which lanes 0..2 carry colour bits 5..0 at the R6 positions. Lane 3 carries colour bits 7,6 at the R7 slot positions.
- R9: With `mirror`=1 each lane delivers slot 6 first and slot 0 last, and pixels decode to the same values as the unmirrored stream.
- R10: Lane 2 slot 0 is data enable, slot 1 is vertical sync and slot 2 is horizontal sync.
- R11: When an emitted word in packing 1 or 2 has lane 3 slot 0 set, `ctl3_err` becomes 1 and stays 1 until `err_clr` is asserted. In packing 0 that slot never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot-rate clock, one bit slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_clk | input | 1 | Sampled clock-lane bit |
| lane_data | input | DATA_LANES | Sampled data-lane bits, bit n is lane n |
| map_sel | input | 2 | Colour packing: 0 six-bit, 1 lane 3 low bits, 2 lane 3 high bits, 3 as 0 |
| mirror | input | 1 | Slots of each word arrive in reverse order |
| err_clr | input | 1 | Clears the reserved-slot error flag |
| pix_valid | output | 1 | One-cycle strobe per recovered pixel |
| pix_red | output | 8 | Red component |
| pix_green | output | 8 | Green component |
| pix_blue | output | 8 | Blue component |
| pix_hsync | output | 1 | Horizontal sync |
| pix_vsync | output | 1 | Vertical sync |
| pix_de | output | 1 | Data enable |
| locked | output | 1 | Word alignment held |
| ctl3_err | output | 1 | Sticky flag: reserved control slot seen set |

## Verification
The hardest case to produce is the lock hysteresis. It needs a locked link, then exactly one corrupted word followed by a clean one, and later two corrupted words in a row, all without slipping the slot phase. The bench serializes every word in a task that never inserts idle slots. Corrupted words are made by forcing the clock lane low for a whole word, so the phase counter keeps running while only the boundary check fails. The bench samples lock state and the pixel count early in the following word, which shows whether the damaged word produced a pixel and whether lock survived it.

// File: rtl/lvds_rx_pkg.sv
package lvds_rx_pkg;

   localparam int SLOTS = 7;

   // Bit 6 holds slot 0 (first received); the shape is symmetric, so
   // mirrored words carry the same value.
   localparam logic [SLOTS-1:0] CLK_WORD = 7'b1100011;

   typedef enum logic [1:0] {
      MAP_6B      = 2'd0,
      MAP_8B_LOW  = 2'd1,
      MAP_8B_HIGH = 2'd2,
      MAP_RSVD    = 2'd3
   } map_e;

   typedef struct packed {
      logic [7:0] red;
      logic [7:0] green;
      logic [7:0] blue;
      logic       hs;
      logic       vs;
      logic       de;
      logic       ctl3;
   } pix_t;

endpackage

// File: rtl/lvds_rx_shift.sv
module lvds_rx_shift #(
   parameter int LANES = 5,
   parameter int DEPTH = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [LANES-1:0]            din,
   output logic [LANES-1:0][DEPTH-1:0] win
);

   initial assert (DEPTH >= 2 && LANES >= 1)
      else $error("lvds_rx_shift: DEPTH must be at least 2");

   // Newest slot enters at bit 0; bit DEPTH-1 is the oldest slot held.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win <= '0;
      end else begin
         for (int i = 0; i < LANES; i++) begin
            win[i] <= {win[i][DEPTH-2:0], din[i]};
         end
      end
   end

endmodule

// File: rtl/lvds_rx_align.sv
module lvds_rx_align
   import lvds_rx_pkg::*;
#(
   parameter int LOCK_WORDS = 3,
   parameter int DROP_WORDS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] clk_win,
   output logic             locked,
   output logic             emit
);

   localparam int PH_W = $clog2(SLOTS);
   localparam int LW_W = $clog2(LOCK_WORDS + 1);
   localparam int DW_W = $clog2(DROP_WORDS + 1);

   initial assert (LOCK_WORDS >= 2 && DROP_WORDS >= 1)
      else $error("lvds_rx_align: LOCK_WORDS >= 2 and DROP_WORDS >= 1 required");

   logic            hunting;
   logic [PH_W-1:0] ph;
   logic [LW_W-1:0] hits;
   logic [DW_W-1:0] misses;
   logic            good;
   logic            boundary;

   assign good     = (clk_win == CLK_WORD);
   assign boundary = hunting ? good : (ph == PH_W'(SLOTS - 1));
   assign emit     = boundary && !hunting && good &&
                     (locked || hits == LW_W'(LOCK_WORDS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hunting <= 1'b1;
         ph      <= '0;
         hits    <= '0;
         misses  <= '0;
         locked  <= 1'b0;
      end else begin
         ph <= (boundary || ph == PH_W'(SLOTS - 1)) ? '0 : ph + PH_W'(1);
         if (hunting) begin
            if (good) begin
               hunting <= 1'b0;
               hits    <= LW_W'(1);
               misses  <= '0;
            end
         end else if (boundary) begin
            if (!locked) begin
               if (!good) begin
                  hunting <= 1'b1;
                  hits    <= '0;
               end else if (hits == LW_W'(LOCK_WORDS - 1)) begin
                  locked <= 1'b1;
                  hits   <= '0;
               end else begin
                  hits <= hits + LW_W'(1);
               end
            end else begin
               if (good) begin
                  misses <= '0;
               end else if (misses == DW_W'(DROP_WORDS - 1)) begin
                  locked  <= 1'b0;
                  hunting <= 1'b1;
                  misses  <= '0;
               end else begin
                  misses <= misses + DW_W'(1);
               end
            end
         end
      end
   end

   AST_LOCK_ONLY_TRACKING: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !hunting); // R5
   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ph < PH_W'(SLOTS)); // R3
   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(hits) == LW_W'(LOCK_WORDS - 1)); // R2
   AST_DROP_AFTER_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> ($past(misses) == DW_W'(DROP_WORDS - 1)) && !$past(good)); // R4

endmodule

// File: rtl/lvds_rx_map.sv
module lvds_rx_map
   import lvds_rx_pkg::*;
#(
   parameter int DATA_LANES = 4
) (
   input  logic [DATA_LANES-1:0][SLOTS-1:0] win,
   input  map_e                             mode,
   input  logic                             mirror,
   output pix_t                             pix
);

   initial assert (DATA_LANES == 3 || DATA_LANES == 4)
      else $error("lvds_rx_map: DATA_LANES must be 3 or 4");

   // Reorders a shift window so index s is slot s.
   function automatic logic [SLOTS-1:0] to_slots(input logic [SLOTS-1:0] w,
                                                 input logic rev);
      logic [SLOTS-1:0] o;
      for (int s = 0; s < SLOTS; s++) begin
         o[s] = rev ? w[s] : w[SLOTS-1-s];
      end
      return o;
   endfunction

   logic [SLOTS-1:0] sl [4];

   for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
      assign sl[l] = to_slots(win[l], mirror);
   end
   if (DATA_LANES == 3) begin : g_no_lane3
      assign sl[3] = '0;
   end

   logic [5:0] r6, g6, b6;
   logic [1:0] r2, g2, b2;

   assign r6 = {sl[0][1], sl[0][2], sl[0][3], sl[0][4], sl[0][5], sl[0][6]};
   assign g6 = {sl[1][2], sl[1][3], sl[1][4], sl[1][5], sl[1][6], sl[0][0]};
   assign b6 = {sl[2][3], sl[2][4], sl[2][5], sl[2][6], sl[1][0], sl[1][1]};
   assign r2 = {sl[3][5], sl[3][6]};
   assign g2 = {sl[3][3], sl[3][4]};
   assign b2 = {sl[3][1], sl[3][2]};

   always_comb begin
      pix.hs   = sl[2][2];
      pix.vs   = sl[2][1];
      pix.de   = sl[2][0];
      pix.ctl3 = sl[3][0];
      case (mode)
         MAP_8B_LOW: begin
            pix.red   = {r6, r2};
            pix.green = {g6, g2};
            pix.blue  = {b6, b2};
         end
         MAP_8B_HIGH: begin
            pix.red   = {r2, r6};
            pix.green = {g2, g6};
            pix.blue  = {b2, b6};
         end
         default: begin
            pix.red   = {r6, r6[5:4]};
            pix.green = {g6, g6[5:4]};
            pix.blue  = {b6, b6[5:4]};
         end
      endcase
   end

endmodule

// File: rtl/lvds_rx_unpack.sv
module lvds_rx_unpack
   import lvds_rx_pkg::*;
#(
   parameter int DATA_LANES = 4,
   parameter int LOCK_WORDS = 3,
   parameter int DROP_WORDS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lane_clk,
   input  logic [DATA_LANES-1:0] lane_data,
   input  logic [1:0]            map_sel,
   input  logic                  mirror,
   input  logic                  err_clr,
   output logic                  pix_valid,
   output logic [7:0]            pix_red,
   output logic [7:0]            pix_green,
   output logic [7:0]            pix_blue,
   output logic                  pix_hsync,
   output logic                  pix_vsync,
   output logic                  pix_de,
   output logic                  locked,
   output logic                  ctl3_err
);

   localparam int ALL_LANES = DATA_LANES + 1;

   initial assert (DATA_LANES == 3 || DATA_LANES == 4)
      else $error("lvds_rx_unpack: DATA_LANES must be 3 or 4");

   logic [ALL_LANES-1:0][SLOTS-1:0]  win;
   logic [DATA_LANES-1:0][SLOTS-1:0] data_win;
   logic                             emit;
   map_e                             mode;
   pix_t                             pix;
   logic                             wide;

   lvds_rx_shift #(.LANES(ALL_LANES), .DEPTH(SLOTS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({lane_clk, lane_data}),
      .win   (win)
   );

   lvds_rx_align #(.LOCK_WORDS(LOCK_WORDS), .DROP_WORDS(DROP_WORDS)) u_align (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_win (win[DATA_LANES]),
      .locked  (locked),
      .emit    (emit)
   );

   assign data_win = win[DATA_LANES-1:0];
   assign mode     = map_e'(map_sel);
   assign wide     = (mode == MAP_8B_LOW) || (mode == MAP_8B_HIGH);

   lvds_rx_map #(.DATA_LANES(DATA_LANES)) u_map (
      .win    (data_win),
      .mode   (mode),
      .mirror (mirror),
      .pix    (pix)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_valid <= 1'b0;
         pix_red   <= '0;
         pix_green <= '0;
         pix_blue  <= '0;
         pix_hsync <= 1'b0;
         pix_vsync <= 1'b0;
         pix_de    <= 1'b0;
         ctl3_err  <= 1'b0;
      end else begin
         pix_valid <= emit;
         if (emit) begin
            pix_red   <= pix.red;
            pix_green <= pix.green;
            pix_blue  <= pix.blue;
            pix_hsync <= pix.hs;
            pix_vsync <= pix.vs;
            pix_de    <= pix.de;
         end
         if (emit && wide && pix.ctl3) begin
            ctl3_err <= 1'b1;
         end else if (err_clr) begin
            ctl3_err <= 1'b0;
         end
      end
   end

   AST_PIX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> locked); // R2
   AST_PIX_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> !pix_valid); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl3_err && !err_clr) |=> ctl3_err); // R11
   AST_ERR_FROM_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl3_err) |-> pix_valid); // R11

endmodule

// File: tb/tb_lvds_rx_unpack.sv
`timescale 1ns/1ps
module tb_lvds_rx_unpack;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lane_clk = 1'b0;
   logic [3:0] lane_data = '0;
   logic [1:0] map_sel = 2'd0;
   logic       mirror = 1'b0;
   logic       err_clr = 1'b0;
   logic       pix_valid;
   logic [7:0] pix_red, pix_green, pix_blue;
   logic       pix_hsync, pix_vsync, pix_de, locked, ctl3_err;

   always #2.5 clk = ~clk;

   lvds_rx_unpack dut (
      .clk(clk), .rst_n(rst_n), .lane_clk(lane_clk), .lane_data(lane_data),
      .map_sel(map_sel), .mirror(mirror), .err_clr(err_clr),
      .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
      .pix_blue(pix_blue), .pix_hsync(pix_hsync), .pix_vsync(pix_vsync),
      .pix_de(pix_de), .locked(locked), .ctl3_err(ctl3_err)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [26:0] cap_pix [32];
   int          ncap = 0;
   logic [26:0] exp_pix [32];
   string       exp_tag [32];
   int          nexp = 0;

   logic lk_s, er_s;
   int   cn_s;

   // mode, mirror, red, green, blue, {hs, vs, de}
   localparam logic [29:0] VEC [8] = '{
      {2'd0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 3'b101},
      {2'd0, 1'b1, 8'h12, 8'hED, 8'h7B, 3'b010},
      {2'd1, 1'b0, 8'hA5, 8'h3C, 8'h0F, 3'b111},
      {2'd1, 1'b1, 8'h81, 8'h7E, 8'hC3, 3'b001},
      {2'd2, 1'b0, 8'hA5, 8'h3C, 8'h0F, 3'b100},
      {2'd2, 1'b1, 8'h56, 8'h9A, 8'hE1, 3'b011},
      {2'd1, 1'b0, 8'hFF, 8'h00, 8'h55, 3'b000},
      {2'd2, 1'b0, 8'h00, 8'hFF, 8'hAA, 3'b111}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   always @(posedge clk) begin
      #1;
      if (pix_valid && ncap < 32) begin
         cap_pix[ncap] = {pix_red, pix_green, pix_blue, pix_hsync, pix_vsync, pix_de};
         ncap++;
      end
   end

   // Serializes one word; samples lock, error flag and pixel count just
   // before driving slot 1, which reflects the previous word.
   task automatic send_word(input logic [1:0] md, input logic mr,
                            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                            input logic hs, input logic vs, input logic de, input logic c3,
                            input logic bad, input logic clr, input logic want, input string tag);
      logic [6:0] ck, w0, w1, w2, w3;
      logic [5:0] r6, g6, b6;
      logic [1:0] r2, g2, b2;
      ck = 7'b1100011;
      r6 = (md == 2'd2) ? r[5:0] : r[7:2];
      g6 = (md == 2'd2) ? g[5:0] : g[7:2];
      b6 = (md == 2'd2) ? b[5:0] : b[7:2];
      r2 = (md == 2'd2) ? r[7:6] : r[1:0];
      g2 = (md == 2'd2) ? g[7:6] : g[1:0];
      b2 = (md == 2'd2) ? b[7:6] : b[1:0];
      w0[0] = g6[0];
      for (int k = 1; k < 7; k++) w0[k] = r6[6-k];
      w1[0] = b6[1];
      w1[1] = b6[0];
      for (int k = 2; k < 7; k++) w1[k] = g6[7-k];
      w2[0] = de; w2[1] = vs; w2[2] = hs;
      for (int k = 3; k < 7; k++) w2[k] = b6[8-k];
      w3 = {r2[0], r2[1], g2[0], g2[1], b2[0], b2[1], c3};
      if (md == 2'd0) w3 = 7'h7F;
      for (int k = 0; k < 7; k++) begin
         int s;
         @(negedge clk);
         if (k == 1) begin
            lk_s = locked;
            er_s = ctl3_err;
            cn_s = ncap;
            map_sel = md;
            mirror  = mr;
         end
         err_clr = clr && (k == 3);
         s = mr ? 6 - k : k;
         lane_clk  = bad ? 1'b0 : ck[s];
         lane_data = {w3[s], w2[s], w1[s], w0[s]};
      end
      if (want) begin
         if (md == 2'd0)
            exp_pix[nexp] = {r[7:2], r[7:6], g[7:2], g[7:6], b[7:2], b[7:6], hs, vs, de};
         else
            exp_pix[nexp] = {r, g, b, hs, vs, de};
         exp_tag[nexp] = tag;
         nexp++;
      end
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 locked in reset", 32'(locked), 32'd0);
      chk("R1 pix_valid in reset", 32'(pix_valid), 32'd0);
      chk("R1 ctl3_err in reset", 32'(ctl3_err), 32'd0);
      rst_n = 1'b1;

      // R3: three stray slots shift the word phase
      repeat (3) begin
         @(negedge clk);
         lane_clk = 1'b0;
         lane_data = 4'h0;
      end
      send_word(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "warm");
      send_word(2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, "warm");

      // Table walk: every entry is emitted
      for (int i = 0; i < 8; i++) begin
         logic [29:0] v;
         string t;
         v = VEC[i];
         t = (v[29:28] == 2'd0) ? "R6" : (v[29:28] == 2'd1) ? "R7" : "R8";
         if (v[27]) t = {t, " R9"};
         t = {t, " R10 R3"};
         send_word(v[29:28], v[27], v[26:19], v[18:11], v[10:3],
                   v[2], v[1], v[0], 1'b0, 1'b0, 1'b0, 1'b1, t);
         if (i == 0) chk("R2 not locked after two words", 32'(lk_s), 32'd0);
         if (i == 1) chk("R2 locked after third word", 32'(lk_s), 32'd1);
         if (i == 2) chk("R11 reserved slot ignored in six-bit mode", 32'(er_s), 32'd0);
      end

      // R11: reserved control slot error
      send_word(2'd1, 1'b0, 8'h11, 8'h22, 8'h33, 0, 0, 1, 1, 0, 0, 1, "R11 R7");
      send_word(2'd1, 1'b0, 8'h44, 8'h55, 8'h66, 1, 0, 1, 0, 0, 0, 1, "R11 R7");
      chk("R11 error set", 32'(er_s), 32'd1);
      send_word(2'd1, 1'b0, 8'h77, 8'h88, 8'h99, 0, 1, 0, 0, 0, 1, 1, "R11 R7");
      chk("R11 error sticky", 32'(er_s), 32'd1);
      send_word(2'd0, 1'b0, 8'hC8, 8'h64, 8'h32, 1, 1, 0, 1, 0, 0, 1, "R11 R6");
      chk("R11 error cleared", 32'(er_s), 32'd0);
      send_word(2'd0, 1'b0, 8'h3C, 8'hC3, 8'h99, 0, 0, 1, 0, 0, 0, 1, "R11 R6");
      chk("R11 six-bit mode keeps flag low", 32'(er_s), 32'd0);

      // R4: one bad word tolerated, two drop lock
      send_word(2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, 0, "bad");
      chk("R4 locked before bad word", 32'(lk_s), 32'd1);
      send_word(2'd2, 1'b0, 8'hDE, 8'hAD, 8'hBE, 1, 0, 1, 0, 0, 0, 1, "R4 R8");
      chk("R4 lock held after single bad word", 32'(lk_s), 32'd1);
      chk("R4 bad word produced no pixel", 32'(cn_s), 32'd13);
      send_word(2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, 0, "bad");
      chk("R4 locked before bad pair", 32'(lk_s), 32'd1);
      send_word(2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, 0, "bad");
      chk("R4 lock held after first of pair", 32'(lk_s), 32'd1);

      // R5: relock after three good words
      send_word(2'd2, 1'b1, 8'h01, 8'h02, 8'h03, 0, 0, 1, 0, 0, 0, 0, "relock");
      chk("R4 lock dropped after two bad words", 32'(lk_s), 32'd0);
      send_word(2'd2, 1'b1, 8'h04, 8'h05, 8'h06, 0, 0, 1, 0, 0, 0, 0, "relock");
      chk("R5 still searching", 32'(lk_s), 32'd0);
      send_word(2'd2, 1'b1, 8'hF1, 8'h2E, 8'h9C, 1, 1, 1, 0, 0, 0, 1, "R5 R8 R9");
      chk("R5 not locked after two good words", 32'(lk_s), 32'd0);
      send_word(2'd1, 1'b0, 8'h6B, 8'hB6, 8'h5A, 0, 1, 1, 0, 0, 0, 1, "R5 R7");
      chk("R5 relocked after third good word", 32'(lk_s), 32'd1);

      repeat (4) @(negedge clk);
      chk("R2 pixel count", 32'(ncap), 32'(nexp));
      for (int i = 0; i < nexp; i++) begin
         chk($sformatf("%s pixel %0d", exp_tag[i], i), 32'(cap_pix[i]), 32'(exp_pix[i]));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule